// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Strobe Generator

This block produces the control strobes for one transfer at a time on a multiplexed address/data local bus in a minimum-mode system. A requester presents a cycle type: memory or I/O space, and read, write or interrupt acknowledge. The block then steps through an optional status-setup state, T1, T2, T3, any wait states and T4. It drives the address latch pulse, the write strobe, the interrupt-acknowledge strobe, the transceiver enable, the transceiver direction and the memory/I/O select. Those strobes control external latches and transceivers, which are not part of this block.

The block runs from a clock at twice the T-state rate, so each T-state has two halves. The first half is called phase 0 and the second half, the mid-state half, is called phase 1. This lets strobe edges fall at the middle of a T-state. The block samples a request at a T-state boundary while idle, or at the boundary into T4 of a running cycle. A request sampled at T4 entry starts T1 directly after that T4. While the hold-acknowledge input is high, the bus-owned outputs are parked at logic one and flagged for tri-stating. No new request is taken during hold.

Top module: `bus_strobe_gen`

## Requirements
- R1: `ale` is high only during phase 1 of T1, exactly one half-state per bus cycle, and hold acknowledge never suppresses it.
- R2: `wr_n` is low during both halves of T2, T3 and every wait state of a write cycle (`req_kind` = 2'b01), and high at all other times.
- R3: `inta_n` is low during T2, T3 and wait states of an acknowledge cycle (`req_kind` = 2'b10), and high otherwise. Hold acknowledge does not affect it.
- R4: For read cycles (`req_kind` = 2'b00, with 2'b11 treated as read) and acknowledge cycles, `den_n` is low from phase 1 of T2 through phase 0 of T4.
- R5: For write cycles, `den_n` is low from phase 0 of T2 through phase 0 of T4.
- R6: `m_io` (1 = memory) and `dt_r` (1 = transmit, set for write cycles) take the new cycle's values at the start of the T-state before its T1. That T-state is the setup state or the preceding T4. The values then hold through that cycle's final T4 and any following idle time.
- R7: At the end of T3 and of each wait state, `ready` is sampled. If it is low, a wait state follows. If it is high, T4 follows.
- R8: A request present at the boundary that enters T4 is accepted (`req_take` high in that half-state), and its T1 follows that T4 directly.
- R9: A request accepted from idle passes through one setup T-state before T1. With no request pending after T4, the bus idles with `ale` low and `wr_n`, `inta_n` and `den_n` high.
- R10: While `hold_ack` is high, the following apply:
  - `m_io`, `wr_n`, `dt_r` and `den_n` read 1.
  - `bus_float` is 1.
  - `req_take` stays low.
- R11: After reset the block is idle in phase 0, with `ale`=0, `wr_n`=`inta_n`=`den_n`=1, `m_io`=1, `dt_r`=0 and `bus_float`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, two edges per T-state |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A bus cycle is requested |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_kind | input | 2 | 00 read, 01 write, 10 interrupt acknowledge, 11 read |
| ready | input | 1 | Slave ready, sampled at the end of T3 and wait states |
| hold_ack | input | 1 | Hold acknowledge: park bus-owned outputs |
| req_take | output | 1 | Request accepted at the coming clock edge |
| ale | output | 1 | Address latch pulse |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| m_io | output | 1 | Space select, 1 = memory |
| bus_float | output | 1 | Bus-owned outputs should be tri-stated |

## Verification
The hardest situation to reach is a back-to-back transfer. Here the second request must be present exactly at the half-state whose closing edge moves T3 into T4. In that case the select lines change during T4 while the transceiver enable still follows the first cycle. The bench reaches this point by counting half-states from the acceptance edge of the first request. It drives `ready` high and presents the second request only in phase 1 of T3. It then checks `req_take`, the new select values in T4, and the address latch pulse in the T-state right after T4. A second case needs hold acknowledge to be raised in the middle of an acknowledge cycle. For that case the bench raises `hold_ack` at a counted half-state inside T1 and T2 and checks which outputs stay live.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  localparam int KIND_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_T1    = 3'd2,
    ST_T2    = 3'd3,
    ST_T3    = 3'd4,
    ST_TW    = 3'd5,
    ST_T4    = 3'd6
  } tstate_e;

  typedef enum logic [KIND_W-1:0] {
    K_READ  = 2'b00,
    K_WRITE = 2'b01,
    K_INTA  = 2'b10,
    K_RSVD  = 2'b11
  } kind_e;

  // address latch pulse: second half of T1
  function automatic logic ale_on(tstate_e s, logic ph);
    return (s == ST_T1) && ph;
  endfunction

  // command strobe window: T2, T3 and wait states
  function automatic logic cmd_on(tstate_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

  // transceiver enable window; writes open at T2 start, others at mid-T2
  function automatic logic den_on(tstate_e s, logic ph, logic is_wr);
    return ((s == ST_T2) && (is_wr || ph)) ||
           (s == ST_T3) || (s == ST_TW) ||
           ((s == ST_T4) && !ph);
  endfunction

endpackage

// File: rtl/bus_tseq.sv
module bus_tseq
  import bus_strobe_pkg::*;
#(
  parameter logic RST_MEM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_mem,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              ready,
  input  logic              hold_ack,
  output tstate_e           st_q,
  output logic              ph_q,
  output logic              stat_mem_q,
  output logic [KIND_W-1:0] stat_kind_q,
  output logic              take
);

  tstate_e st_d;
  logic    pend_q, pend_d;
  logic    to_t4, acc_idle, acc_t4;

  assign to_t4    = ((st_q == ST_T3) || (st_q == ST_TW)) && ready;
  assign acc_idle = (st_q == ST_IDLE) && req_valid && !hold_ack;
  assign acc_t4   = to_t4 && req_valid && !hold_ack;
  assign take     = ph_q && (acc_idle || acc_t4);

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    if (ph_q) begin
      case (st_q)
        ST_IDLE:  if (acc_idle) st_d = ST_SETUP;
        ST_SETUP: st_d = ST_T1;
        ST_T1:    st_d = ST_T2;
        ST_T2:    st_d = ST_T3;
        ST_T3, ST_TW: begin
          st_d = ready ? ST_T4 : ST_TW;
          if (acc_t4) pend_d = 1'b1;
        end
        ST_T4: begin
          st_d   = pend_q ? ST_T1 : ST_IDLE;
          pend_d = 1'b0;
        end
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      ph_q        <= 1'b0;
      pend_q      <= 1'b0;
      stat_mem_q  <= RST_MEM;
      stat_kind_q <= K_READ;
    end else begin
      st_q   <= st_d;
      ph_q   <= ~ph_q;
      pend_q <= pend_d;
      if (take) begin
        stat_mem_q  <= req_mem;
        stat_kind_q <= req_kind;
      end
    end
  end

endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
  import bus_strobe_pkg::*;
(
  input  tstate_e           st,
  input  logic              ph,
  input  logic              stat_mem,
  input  logic [KIND_W-1:0] stat_kind,
  input  logic              hold_ack,
  output logic              ale,
  output logic              wr_n,
  output logic              inta_n,
  output logic              den_n,
  output logic              dt_r,
  output logic              m_io,
  output logic              bus_float
);

  logic is_wr, is_ia;

  assign is_wr = (stat_kind == K_WRITE);
  assign is_ia = (stat_kind == K_INTA);

  // never floated
  assign ale    = ale_on(st, ph);
  assign inta_n = !(cmd_on(st) && is_ia);

  // parked at logic one while the bus is handed away
  assign bus_float = hold_ack;
  assign wr_n  = hold_ack | !(cmd_on(st) && is_wr);
  assign den_n = hold_ack | !den_on(st, ph, is_wr);
  assign dt_r  = hold_ack | is_wr;
  assign m_io  = hold_ack | stat_mem;

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter logic RST_MEM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_mem,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              ready,
  input  logic              hold_ack,
  output logic              req_take,
  output logic              ale,
  output logic              wr_n,
  output logic              inta_n,
  output logic              den_n,
  output logic              dt_r,
  output logic              m_io,
  output logic              bus_float
);

  tstate_e           st_q;
  logic              ph_q;
  logic              stat_mem_q;
  logic [KIND_W-1:0] stat_kind_q;

  bus_tseq #(.RST_MEM(RST_MEM)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_mem     (req_mem),
    .req_kind    (req_kind),
    .ready       (ready),
    .hold_ack    (hold_ack),
    .st_q        (st_q),
    .ph_q        (ph_q),
    .stat_mem_q  (stat_mem_q),
    .stat_kind_q (stat_kind_q),
    .take        (req_take)
  );

  bus_strobe_dec u_dec (
    .st        (st_q),
    .ph        (ph_q),
    .stat_mem  (stat_mem_q),
    .stat_kind (stat_kind_q),
    .hold_ack  (hold_ack),
    .ale       (ale),
    .wr_n      (wr_n),
    .inta_n    (inta_n),
    .den_n     (den_n),
    .dt_r      (dt_r),
    .m_io      (m_io),
    .bus_float (bus_float)
  );

endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk
  import bus_strobe_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    ready,
  input logic    hold_ack,
  input logic    req_take,
  input logic    ale,
  input logic    wr_n,
  input logic    inta_n,
  input logic    den_n,
  input logic    m_io,
  input logic    dt_r,
  input tstate_e st_q,
  input logic    ph_q
);

  // checker-side note of a request taken on the way into T4
  logic took_t4;
  always_ff @(posedge clk) begin
    if (!rst_n)
      took_t4 <= 1'b0;
    else if (req_take && (st_q == ST_T3 || st_q == ST_TW))
      took_t4 <= 1'b1;
    else if (st_q == ST_T4 && ph_q)
      took_t4 <= 1'b0;
  end

  AST_ALE_SINGLE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R1
  AST_ALE_IN_T1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (st_q == ST_T1)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!wr_n, !inta_n})); // R3
  AST_WR_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (wr_n && inta_n && den_n && !ale)); // R9
  AST_DEN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T4 && ph_q) |-> den_n); // R4
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_T1 || st_q == ST_T2 || st_q == ST_T3 || st_q == ST_TW) &&
     !hold_ack && $past(!hold_ack)) |-> ($stable(m_io) && $stable(dt_r))); // R6
  AST_WAIT_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_T3 || st_q == ST_TW) && ph_q && !ready) |=> (st_q == ST_TW)); // R7
  AST_B2B_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T4 && ph_q && took_t4) |=> (st_q == ST_T1)); // R8
  AST_HOLD_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> !req_take); // R10

endmodule

bind bus_strobe_gen bus_strobe_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .hold_ack (hold_ack),
  .req_take (req_take),
  .ale      (ale),
  .wr_n     (wr_n),
  .inta_n   (inta_n),
  .den_n    (den_n),
  .m_io     (m_io),
  .dt_r     (dt_r),
  .st_q     (st_q),
  .ph_q     (ph_q)
);

// File: tb/bus_strobe_gen_test.sv
`timescale 1ns/1ps
module bus_strobe_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_mem = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic       ready = 1'b1;
  logic       hold_ack = 1'b0;
  logic       req_take, ale, wr_n, inta_n, den_n, dt_r, m_io, bus_float;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mem(req_mem),
    .req_kind(req_kind), .ready(ready), .hold_ack(hold_ack),
    .req_take(req_take), .ale(ale), .wr_n(wr_n), .inta_n(inta_n),
    .den_n(den_n), .dt_r(dt_r), .m_io(m_io), .bus_float(bus_float)
  );

  // {mem, kind[1:0], waits[1:0]}
  localparam int NV = 6;
  localparam logic [4:0] VEC [NV] = '{
    5'b1_00_00,  // memory read, no wait
    5'b0_01_00,  // I/O write, no wait
    5'b1_01_10,  // memory write, two waits
    5'b0_10_01,  // I/O acknowledge, one wait
    5'b1_00_11,  // memory read, three waits
    5'b0_11_00   // reserved kind behaves as read
  };

  // packed observation {ale, wr_n, inta_n, den_n, m_io, dt_r, bus_float}
  function automatic logic [6:0] obs();
    return {ale, wr_n, inta_n, den_n, m_io, dt_r, bus_float};
  endfunction

  // expected view of half-state k after acceptance from idle
  function automatic logic [6:0] expect_at(int k, logic mem, logic [1:0] kind,
                                           int waits, logic hld);
    int  s = k / 2;
    logic p = logic'(k % 2);
    logic w = (kind == 2'b01);
    logic a = (kind == 2'b10);
    int  last = 3 + waits;
    int  t4 = 4 + waits;
    logic cmd = (s >= 2) && (s <= last);
    logic en = ((s == 2) && (w || p)) || ((s > 2) && (s <= last)) ||
               ((s == t4) && !p);
    logic e_ale = (s == 1) && p;
    logic e_ia  = !(cmd && a);
    if (hld) return {e_ale, 1'b1, e_ia, 1'b1, 1'b1, 1'b1, 1'b1};
    return {e_ale, !(cmd && w), e_ia, !en, mem, w, 1'b0};
  endfunction

  task automatic chk(string req, logic [6:0] got, logic [6:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (ale wr_n inta_n den_n m_io dt_r float)",
               req, got, exp);
    end
  endtask

  task automatic chk1(string req, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wait_take();
    req_valid = 1'b1;
    #1;
    while (!req_take) begin
      @(negedge clk);
      #1;
    end
  endtask

  // one isolated cycle from idle; hold high for half-states hlo..hhi
  task automatic run_cycle(logic mem, logic [1:0] kind, int waits, int hlo, int hhi);
    int t4 = 4 + waits;
    req_mem = mem;
    req_kind = kind;
    wait_take();
    for (int k = 0; k <= 2 * t4 + 3; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      ready = ((k / 2) == 3 + waits);
      hold_ack = (k >= hlo) && (k <= hhi);
      #1;
      // R1 R2 R3 R4 R5 R6 R7 R9 R10
      chk($sformatf("R1/R2/R3/R4/R5/R6/R7/R9 kind=%0d waits=%0d half=%0d", kind, waits, k),
          obs(), expect_at(k, mem, kind, waits, hold_ack));
    end
    hold_ack = 1'b0;
    ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset", obs(), 7'b0_1_1_1_1_0_0);
    chk1("R11 reset take", req_take, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R11 after release", obs(), 7'b0_1_1_1_1_0_0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      run_cycle(VEC[i][4], VEC[i][3:2], int'(VEC[i][1:0]), 99, 99);
      repeat (3) @(negedge clk);
    end

    // R10: hold while idle blocks acceptance and parks outputs
    @(negedge clk);
    hold_ack = 1'b1;
    req_valid = 1'b1;
    req_mem = 1'b0;
    req_kind = 2'b00;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk1("R10 no take in hold", req_take, 1'b0);
      chk("R10 idle park", obs(), 7'b0_1_1_1_1_1_1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
    hold_ack = 1'b0;
    @(negedge clk);

    // R10 R1 R3: hold raised mid acknowledge cycle, ale and inta_n stay live
    run_cycle(1'b0, 2'b10, 0, 2, 5);
    repeat (3) @(negedge clk);

    // R8: back-to-back, second request presented in phase 1 of T3
    req_mem = 1'b1;
    req_kind = 2'b00;
    ready = 1'b1;
    wait_take();
    for (int k = 0; k <= 13; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (k == 7) begin
        req_mem = 1'b0;
        req_kind = 2'b01;
        req_valid = 1'b1;
      end
      if (k == 8) req_valid = 1'b0;
      #1;
      if (k == 7) chk1("R8 take at T4 entry", req_take, 1'b1);
      if (k == 8) chk("R6 R8 status set in T4", obs(), 7'b0_1_1_0_0_1_0);
      if (k == 9) chk("R8 T4 second half", obs(), 7'b0_1_1_1_0_1_0);
      if (k == 10) chk("R8 T1 first half", obs(), 7'b0_1_1_1_0_1_0);
      if (k == 11) chk("R8 T1 ale directly after T4", obs(), 7'b1_1_1_1_0_1_0);
      if (k == 12) chk("R5 R8 write T2 opens den", obs(), 7'b0_0_1_0_0_1_0);
    end
    repeat (8) @(negedge clk);
    #1;
    chk("R9 idle after back-to-back", obs(), 7'b0_1_1_1_0_1_0);

    // R11: reset mid-cycle returns to idle state
    req_mem = 1'b1;
    req_kind = 2'b01;
    wait_take();
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R11 reset mid-cycle", obs(), 7'b0_1_1_1_1_0_0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule